// File: doc/BRIEF.md
# Reloadable Down-Counting Tick Timer

This block is a periodic tick source for a processor subsystem. A down-counter, 24 bits wide by default, runs from a software-programmed reload value. Each time it steps from one to zero it sets a sticky status flag. It can also pulse an interrupt request for one clock. On the next counting step it reloads, so a reload value of N gives a period of N+1 counting steps.

The counter steps on every clock when the core-clock source is selected. Otherwise it steps only on clocks where the already-synchronised one-cycle `ref_tick` strobe is high. Software reaches the block through a plain register port with word addressing. The port has four registers:

- control/status, at byte offset 0x10
- reload, at 0x14
- current count, at 0x18
- a read-only calibration word, at 0x1C

Read data is combinational in the same cycle as the request. The side effect of a read, which clears the flag, takes place at the clock edge that closes the request. The calibration word and the absence of a reference clock are fixed by parameters.

Top module: `tick_timer`

## Requirements
- R1: Registers sit at byte offsets 0x10 (control/status), 0x14 (reload), 0x18 (current count) and 0x1C (calibration). Any other address, including a non-word-aligned one, reads as zero, and writes to it change nothing.
- R2: Control/status layout: bit 0 enables counting, bit 1 enables the tick interrupt, bit 2 selects the core clock (1) or the reference strobe (0), and bit 16 is the sticky count flag. All other bits read zero.
- R3: The flag is set and the interrupt is raised at the step from 1 to 0, so reload value N gives one event every N+1 counting steps.
- R4: The reload register holds bits 23:0 of the written data, and bits 31:24 read as zero.
- R5: The flag stays set until a read of control/status, and that read clears it. If the counter reaches zero at the same edge as the clearing read, the flag stays set.
- R6: Any write to the current-count register sets the count to zero and clears the flag, whatever the data. That write raises no interrupt, even at the edge where a 1-to-0 step was due.
- R7: The calibration word reads {NOREF, SKEW, 6'b0, TENMS[23:0]} from parameters, and writes to it are ignored.
- R8: When the block is built without a reference clock (NOREF=1), the clock-source bit reads 1, and writing 0 cannot clear it.
- R9: While enabled, a counting step taken at count zero loads the reload value. A reload value of zero holds the count at zero and produces no flag and no interrupt.
- R10: With the reference strobe selected, the count changes only on clocks where `ref_tick` is high.
- R11: `tick_irq` is a single-clock pulse, raised only while both the enable bit and the interrupt-enable bit are set.
- R12: After synchronous reset, all control bits, the flag, the reload value, the count and `tick_irq` are zero. The exception is the clock-source bit, which reads 1 when NOREF=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the core counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle, zero otherwise |
| ref_tick | input | 1 | Synchronised one-cycle reference-tick strobe |
| tick_irq | output | 1 | One-clock tick interrupt pulse |

## Verification
The assertions assume that `ref_tick` has already been synchronised to `clk` and that each request on the register port lasts exactly one clock, with address and data held steady from before the edge. The bench drives every input half a period away from the rising edge and releases `bus_sel` right after the edge it was meant for. It pulses `ref_tick` for single clocks only. Before each timing case it clears the count through a current-count write, so each case starts from a known count of zero.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CAL_W  = 24;

    // byte offsets of the four registers
    localparam logic [7:0] OFS_CSR = 8'h10;
    localparam logic [7:0] OFS_RLD = 8'h14;
    localparam logic [7:0] OFS_CUR = 8'h18;
    localparam logic [7:0] OFS_CAL = 8'h1C;

    // control/status bit positions
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_IE   = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CSR,
        REG_RLD,
        REG_CUR,
        REG_CAL
    } reg_id_e;

    typedef struct packed {
        logic en;        // counting enabled
        logic irq_en;    // interrupt on reaching zero
        logic core_clk;  // 1: count every clock, 0: count on ref strobe
    } ctrl_t;

    typedef struct packed {
        logic rd_csr;
        logic wr_csr;
        logic wr_rld;
        logic wr_cur;
    } bus_ev_t;

    function automatic logic [DATA_W-1:0] pack_csr(input ctrl_t c, input logic flag);
        logic [DATA_W-1:0] r;
        r           = '0;
        r[BIT_EN]   = c.en;
        r[BIT_IE]   = c.irq_en;
        r[BIT_SRC]  = c.core_clk;
        r[BIT_FLAG] = flag;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cal(input logic noref, input logic skew,
                                                   input logic [CAL_W-1:0] tenms);
        logic [DATA_W-1:0] r;
        r              = '0;
        r[CAL_W-1:0]   = tenms;
        r[DATA_W-2]    = skew;
        r[DATA_W-1]    = noref;
        return r;
    endfunction

endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
    import tick_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           id,
    output bus_ev_t           ev
);

    always_comb begin
        id = REG_NONE;
        if      (addr == ADDR_W'(OFS_CSR)) id = REG_CSR;
        else if (addr == ADDR_W'(OFS_RLD)) id = REG_RLD;
        else if (addr == ADDR_W'(OFS_CUR)) id = REG_CUR;
        else if (addr == ADDR_W'(OFS_CAL)) id = REG_CAL;
    end

    always_comb begin
        ev.rd_csr = sel && !we && (id == REG_CSR);
        ev.wr_csr = sel &&  we && (id == REG_CSR);
        ev.wr_rld = sel &&  we && (id == REG_RLD);
        ev.wr_cur = sel &&  we && (id == REG_CUR);
    end

    // at most one register event per cycle (R1)
    always_comb begin
        assert_one_event_R1: assert ($countones(ev) <= 1);
    end

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 24,
    parameter bit          NO_REF = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [2:0]       csr_wdata,
    input  logic [CNT_W-1:0] rld_wdata,
    output ctrl_t            ctl,
    output logic [CNT_W-1:0] reload
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.en       <= 1'b0;
            ctl.irq_en   <= 1'b0;
            ctl.core_clk <= NO_REF;
            reload       <= '0;
        end else begin
            if (ev.wr_csr) begin
                ctl.en       <= csr_wdata[BIT_EN];
                ctl.irq_en   <= csr_wdata[BIT_IE];
                ctl.core_clk <= csr_wdata[BIT_SRC] | NO_REF;
            end
            if (ev.wr_rld) begin
                reload <= rld_wdata;
            end
        end
    end

    // control bits move only on a control write (R2)
    assert_ctl_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !ev.wr_csr |=> $stable(ctl));

    // reload value moves only on a reload write (R4)
    assert_rld_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !ev.wr_rld |=> $stable(reload));

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctl,
    input  logic [CNT_W-1:0] reload,
    input  logic             ref_tick,
    input  bus_ev_t          ev,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    logic at_one;
    logic hit_zero;

    assign step     = ctl.en && (ctl.core_clk || ref_tick);
    assign at_one   = (count == ONE);
    assign hit_zero = step && at_one && !ev.wr_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            flag  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (ev.wr_cur) begin
                count <= '0;
                flag  <= 1'b0;
            end else begin
                if (step) begin
                    if (count == '0) count <= reload;
                    else             count <= count - ONE;
                end
                if (hit_zero) begin
                    flag <= 1'b1;
                    irq  <= ctl.irq_en;
                end else if (ev.rd_csr) begin
                    flag <= 1'b0;
                end
            end
        end
    end

    // R3: reaching zero leaves the flag set
    assert_flag_on_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (step && at_one && !ev.wr_cur) |=> flag);

    // R5: a flag already set survives until a status read or count write
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (flag && !ev.rd_csr && !ev.wr_cur) |=> flag);

    // R6: count write clears count and flag, no interrupt
    assert_cur_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ev.wr_cur |=> (count == '0 && !flag && !irq));

    // R9: zero reload keeps the counter parked at zero
    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (reload == '0 && count == '0) |=> (count == '0));

    // R10: no counting step, no change
    assert_no_step_R10: assert property (@(posedge clk) disable iff (rst)
        (!step && !ev.wr_cur) |=> $stable(count));

    // R11: interrupt is gated and lasts one clock
    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ctl.en && ctl.irq_en));
    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned     CNT_W     = 24,
    parameter int unsigned     ADDR_W    = 8,
    parameter logic [CAL_W-1:0] CAL_TENMS = '0,
    parameter bit              CAL_SKEW  = 1'b0,
    parameter bit              NO_REF    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic              tick_irq
);

    reg_id_e          reg_id;
    bus_ev_t          bus_ev;
    ctrl_t            ctl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             flag;
    logic             rd_req;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign rd_req       = bus_sel && !bus_we;

    tick_timer_decode #(
        .ADDR_W (ADDR_W)
    ) decode_i (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .id   (reg_id),
        .ev   (bus_ev)
    );

    tick_timer_ctrl #(
        .CNT_W  (CNT_W),
        .NO_REF (NO_REF)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .ev        (bus_ev),
        .csr_wdata (bus_wdata[2:0]),
        .rld_wdata (bus_wdata[CNT_W-1:0]),
        .ctl       (ctl),
        .reload    (reload)
    );

    tick_timer_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .reload   (reload),
        .ref_tick (ref_tick),
        .ev       (bus_ev),
        .count    (count),
        .flag     (flag),
        .irq      (tick_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_req) begin
            case (reg_id)
                REG_CSR: bus_rdata = pack_csr(ctl, flag);
                REG_RLD: bus_rdata = DATA_W'(reload);
                REG_CUR: bus_rdata = DATA_W'(count);
                REG_CAL: bus_rdata = pack_cal(NO_REF, CAL_SKEW, CAL_TENMS);
                default: bus_rdata = '0;
            endcase
        end
    end

    // R1: nothing drives read data outside a read request
    assert_idle_rdata_R1: assert property (@(posedge clk) disable iff (rst)
        !rd_req |-> (bus_rdata == '0));

    generate
        if (CNT_W < DATA_W) begin : g_upper
            // R4: upper reload bits read zero
            assert_rld_upper_R4: assert property (@(posedge clk) disable iff (rst)
                (rd_req && bus_addr == ADDR_W'(OFS_RLD)) |-> (bus_rdata[DATA_W-1:CNT_W] == '0));
        end
        if (NO_REF) begin : g_noref
            // R8: clock-source bit pinned high
            assert_src_pinned_R8: assert property (@(posedge clk) disable iff (rst)
                (rd_req && bus_addr == ADDR_W'(OFS_CSR)) |-> bus_rdata[BIT_SRC]);
        end
    endgenerate

endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;

    localparam logic [23:0] TB_TENMS = 24'h0493E0;
    localparam logic [7:0]  A_CSR = 8'h10, A_RLD = 8'h14, A_CUR = 8'h18, A_CAL = 8'h1C;

    typedef struct packed {
        logic [23:0] rld;
        logic [7:0]  wait_n;
        logic        ie;
        logic [23:0] exp_cur;
        logic        exp_flag;
        logic [3:0]  exp_irq;
    } vec_t;

    // counting edges k = wait_n + 1; count = rld - ((k-1) mod (rld+1))
    localparam vec_t VECS [7] = '{
        '{24'd5,       8'd3,  1'b1, 24'd2,       1'b0, 4'd0},
        '{24'd5,       8'd5,  1'b1, 24'd0,       1'b1, 4'd1},
        '{24'd5,       8'd6,  1'b1, 24'd5,       1'b1, 4'd1},
        '{24'd3,       8'd10, 1'b1, 24'd1,       1'b1, 4'd2},
        '{24'd1,       8'd7,  1'b0, 24'd0,       1'b1, 4'd0},
        '{24'd32,      8'd40, 1'b1, 24'd25,      1'b1, 4'd1},
        '{24'hFFFFFF,  8'd2,  1'b1, 24'hFFFFFD,  1'b0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a;
    logic [31:0] rdata_b;
    logic        ref_tick = 1'b0;
    logic        irq_a;
    logic        irq_b;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    int irq_double = 0;
    logic irq_prev = 1'b0;

    always #2 clk = ~clk;

    tick_timer #(
        .CNT_W(24), .ADDR_W(8), .CAL_TENMS(TB_TENMS), .CAL_SKEW(1'b1), .NO_REF(1'b0)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .ref_tick(ref_tick), .tick_irq(irq_a)
    );

    tick_timer #(
        .CNT_W(24), .ADDR_W(8), .CAL_TENMS(TB_TENMS), .CAL_SKEW(1'b1), .NO_REF(1'b1)
    ) dut_nr (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .ref_tick(ref_tick), .tick_irq(irq_b)
    );

    always @(negedge clk) begin
        if (irq_a) irq_cnt++;
        if (irq_a && irq_prev) irq_double++;
        irq_prev <= irq_a;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        da = rdata_a; db = rdata_b;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] va, vb;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check("R12 irq", {31'b0, irq_a}, 32'h0);
        rd(A_CSR, va, vb);
        check("R12 csr", va, 32'h0);
        check("R12 csr noref", vb, 32'h4);
        rd(A_RLD, va, vb); check("R12 reload", va, 32'h0);
        rd(A_CUR, va, vb); check("R12 count", va, 32'h0);

        // R7: calibration word, read-only
        rd(A_CAL, va, vb);
        check("R7 cal", va, {1'b0, 1'b1, 6'b0, TB_TENMS});
        check("R7 cal noref", vb, {1'b1, 1'b1, 6'b0, TB_TENMS});
        wr(A_CAL, 32'h0);
        rd(A_CAL, va, vb);
        check("R7 cal after write", va, {1'b0, 1'b1, 6'b0, TB_TENMS});

        // R1: unmapped and misaligned addresses
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, va, vb); check("R1 unmapped", va, 32'h0);
        wr(8'h11, 32'h0000_0007);
        rd(8'h11, va, vb); check("R1 misaligned", va, 32'h0);
        rd(A_CSR, va, vb); check("R1 misaligned write ignored", va, 32'h0);

        // R4: reload field width
        wr(A_RLD, 32'hFFFF_FFFF);
        rd(A_RLD, va, vb); check("R4 reload upper zero", va, 32'h00FF_FFFF);

        // R2: control bit layout
        wr(A_CSR, 32'hFFFF_FFFF);
        rd(A_CSR, va, vb); check("R2 csr layout", va, 32'h0000_0007);
        wr(A_CSR, 32'h0);
        wr(A_CUR, 32'h0);

        // R3 / R9 / R11: table of periods
        foreach (VECS[i]) begin
            wr(A_RLD, {8'h00, VECS[i].rld});
            wr(A_CUR, 32'h0);
            irq_cnt = 0;
            wr(A_CSR, {29'b0, 1'b1, VECS[i].ie, 1'b1});
            repeat (int'(VECS[i].wait_n)) @(negedge clk);
            wr(A_CSR, 32'h0);
            rd(A_CUR, va, vb);
            check($sformatf("R3 count vec%0d", i), va, {8'h00, VECS[i].exp_cur});
            check($sformatf("R11 irq count vec%0d", i), irq_cnt, {28'b0, VECS[i].exp_irq});
            rd(A_CSR, va, vb);
            check($sformatf("R5 flag vec%0d", i), {31'b0, va[16]}, {31'b0, VECS[i].exp_flag});
            rd(A_CSR, va, vb);
            check($sformatf("R5 flag cleared vec%0d", i), {31'b0, va[16]}, 32'h0);
        end

        // R6: count write at the edge where 1->0 was due
        wr(A_RLD, 32'd1);
        wr(A_CUR, 32'h0);
        irq_cnt = 0;
        wr(A_CSR, 32'h7);
        @(negedge clk);
        wr(A_CUR, 32'h0000_ABCD);
        rd(A_CUR, va, vb);
        check("R6 count cleared", va, 32'h0);
        check("R6 no irq", irq_cnt, 32'h0);
        rd(A_CSR, va, vb);
        check("R6 flag not set", va, 32'h0000_0007);
        wr(A_CSR, 32'h0);
        wr(A_CUR, 32'h0);

        // R9: zero reload stays parked
        wr(A_RLD, 32'h0);
        irq_cnt = 0;
        wr(A_CSR, 32'h7);
        repeat (20) @(negedge clk);
        wr(A_CSR, 32'h0);
        rd(A_CUR, va, vb); check("R9 zero reload count", va, 32'h0);
        rd(A_CSR, va, vb); check("R9 zero reload flag", {31'b0, va[16]}, 32'h0);
        check("R9 zero reload irq", irq_cnt, 32'h0);

        // R10: reference strobe mode
        wr(A_RLD, 32'd4);
        wr(A_CUR, 32'h0);
        wr(A_CSR, 32'h1);
        repeat (5) @(negedge clk);
        rd(A_CUR, va, vb); check("R10 no strobe no count", va, 32'h0);
        repeat (3) begin
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            @(negedge clk);
        end
        wr(A_CSR, 32'h0);
        rd(A_CUR, va, vb); check("R10 three strobes", va, 32'd2);

        // R5: read clearing at the same edge the flag sets
        wr(A_RLD, 32'd2);
        wr(A_CUR, 32'h0);
        wr(A_CSR, 32'h5);
        @(negedge clk);
        @(negedge clk);
        rd(A_CSR, va, vb); check("R5 flag before zero", {31'b0, va[16]}, 32'h0);
        wr(A_CSR, 32'h0);
        rd(A_CSR, va, vb); check("R5 set wins over clear", {31'b0, va[16]}, 32'h1);
        rd(A_CSR, va, vb); check("R5 cleared after read", {31'b0, va[16]}, 32'h0);

        // R8: source bit pinned without reference clock
        wr(A_CSR, 32'h0);
        rd(A_CSR, va, vb);
        check("R8 noref source", vb & 32'h7, 32'h4);
        check("R8 ref source clears", va & 32'h7, 32'h0);

        // R11: never two pulses back to back
        check("R11 single-clock pulse", irq_double, 32'h0);

        finish_run();
    end

endmodule